// File: doc/BRIEF.md
# Ingress Frame Policer with Unknown-Unicast Filter

This block sits on a single switch ingress port and decides, once per arriving frame, whether the frame is forwarded or dropped. At frame start it takes the destination address, the frame's byte length and the result of the address lookup. From these it sorts the frame into one of four classes: broadcast, multicast, known unicast or unknown (flooded) unicast.

Software picks, with a four-bit class mask, which classes are metered. The bytes of forwarded, metered frames are summed over a fixed window of 2^WIN_LOG clock cycles. A metered frame that would push the window's sum above the configured limit is dropped whole. A separate configuration bit discards unknown-destination unicast frames before the meter ever sees them. A limit of zero turns policing off. The decision is registered and appears one cycle after the frame-start strobe.

Top module: `ingress_policer`

## Requirements
- R1: Class codes on `dec_class`: 3 = broadcast (destination all ones), 2 = multicast (bit 40 of `frm_dst`, the group bit of the first address byte, set and not broadcast), 1 = unknown unicast (bit 40 clear, `frm_hit` low), 0 = known unicast (bit 40 clear, `frm_hit` high).
- R2: A frame start sampled on a rising edge gives a one-cycle `dec_valid` pulse after that same edge. `dec_valid` and `dec_fwd` stay low in cycles with no decision.
- R3: When `cfg_drop_unknown` is 1, every unknown unicast frame is dropped, and its length is never added to the window's byte sum.
- R4: Bit c of `cfg_class_sel` meters class c. A frame whose class bit is 0 is forwarded, unless R3 drops it, and adds nothing to the sum.
- R5: When `cfg_limit` is non-zero, a metered frame is dropped if the window sum plus `frm_len` exceeds `cfg_limit`. A frame that brings the sum exactly to the limit is forwarded.
- R6: A dropped frame does not add to the window's byte sum, so a later smaller frame can still fit.
- R7: When `cfg_limit` is zero, every metered frame is forwarded.
- R8: Number the rising edges from 1, starting with the first edge after `rst_n` rises. The byte sum restarts from zero at edges 2^WIN_LOG+2, 2*2^WIN_LOG+2, and so on. A frame sampled at such an edge is measured against an empty window.
- R9: While `rst_n` is low, `dec_valid` and `dec_fwd` are 0 and the byte sum is cleared. Frame starts in the first two edges after release are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | One-cycle strobe: frame fields valid |
| frm_dst | input | 48 | Destination address, first byte in bits 47:40 |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_hit | input | 1 | Address lookup found the destination |
| cfg_class_sel | input | 4 | Metered-class mask, indexed by class code |
| cfg_limit | input | CNT_W | Bytes allowed per window, 0 = unlimited |
| cfg_drop_unknown | input | 1 | Discard unknown unicast frames |
| dec_valid | output | 1 | Decision present |
| dec_fwd | output | 1 | 1 = forward, 0 = drop |
| dec_class | output | 2 | Class code of the decided frame |

## Verification
A byte sum that is off by even one frame shows up at the ports only when a later metered frame lands on the limit. The bench therefore drives frames that fill a window to exactly the limit, frames that overshoot it by one byte, and retries after a drop. A window counter with the wrong phase changes the decision for frames on the last cycle of a window and the first cycle of the next, so frames are placed on exactly those edges. A wrong classification or a leaked filter corrupts `dec_class` or `dec_fwd` in the very next cycle.

// File: rtl/ipol_pkg.sv
`timescale 1ns/1ps
package ipol_pkg;
  localparam int unsigned ADDR_W    = 48;
  localparam int unsigned GROUP_BIT = 40;
  localparam int unsigned N_CLASS   = 4;

  typedef enum logic [1:0] {
    CLS_KNOWN   = 2'd0,
    CLS_UNKNOWN = 2'd1,
    CLS_MCAST   = 2'd2,
    CLS_BCAST   = 2'd3
  } frm_class_e;
endpackage

// File: rtl/ipol_rst_sync.sv
`timescale 1ns/1ps
module ipol_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ipol_window.sv
`timescale 1ns/1ps
module ipol_window #(
  parameter int unsigned WIN_LOG = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_last
);
  logic [WIN_LOG-1:0] cnt_q;
  logic [WIN_LOG-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The cycle in which the window holds its final value; the next edge starts a fresh window.
  assign win_last = &cnt_q;
endmodule

// File: rtl/ipol_classify.sv
`timescale 1ns/1ps
module ipol_classify
  import ipol_pkg::*;
(
  input  logic [ADDR_W-1:0] dst,
  input  logic              hit,
  output frm_class_e        cls
);
  always_comb begin
    if (&dst)                cls = CLS_BCAST;
    else if (dst[GROUP_BIT]) cls = CLS_MCAST;
    else if (!hit)           cls = CLS_UNKNOWN;
    else                     cls = CLS_KNOWN;
  end
endmodule

// File: rtl/ipol_meter.sv
`timescale 1ns/1ps
module ipol_meter
  import ipol_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned CNT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   len,
  input  frm_class_e         cls,
  input  logic               win_last,
  input  logic [N_CLASS-1:0] sel,
  input  logic [CNT_W-1:0]   limit,
  input  logic               drop_unk,
  output logic               dv_o,
  output logic               fwd_o,
  output frm_class_e         cls_o
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [SUM_W-1:0] sum;
  logic             metered, filtered, over, accept;
  logic             dv_q, dv_d, fwd_q, fwd_d;
  frm_class_e       cls_q, cls_d;
  logic             cls_en;

  always_comb begin
    base     = win_last ? '0 : cnt_q;
    sum      = {1'b0, base} + SUM_W'(len);
    metered  = sel[cls];
    filtered = drop_unk && (cls == CLS_UNKNOWN);
    over     = (limit != '0) && (sum > {1'b0, limit});
    accept   = !filtered && !(metered && over);
    cnt_d    = base;
    if (start && accept && metered) begin
      cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
    dv_d   = start;
    fwd_d  = start && accept;
    cls_en = start;
    cls_d  = cls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dv_q  <= 1'b0;
      fwd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dv_q  <= dv_d;
      fwd_q <= fwd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cls_q <= CLS_KNOWN;
    else if (cls_en) cls_q <= cls_d;
  end

  assign dv_o  = dv_q;
  assign fwd_o = fwd_q;
  assign cls_o = cls_q;
endmodule

// File: rtl/ingress_policer.sv
`timescale 1ns/1ps
module ingress_policer
  import ipol_pkg::*;
#(
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned WIN_LOG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_start,
  input  logic [47:0]        frm_dst,
  input  logic [LEN_W-1:0]   frm_len,
  input  logic               frm_hit,
  input  logic [3:0]         cfg_class_sel,
  input  logic [CNT_W-1:0]   cfg_limit,
  input  logic               cfg_drop_unknown,
  output logic               dec_valid,
  output logic               dec_fwd,
  output logic [1:0]         dec_class
);
  logic       rst_sync_n;
  logic       win_last;
  frm_class_e cls;
  frm_class_e cls_out;

  ipol_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  ipol_window #(.WIN_LOG(WIN_LOG)) u_win (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .win_last (win_last)
  );

  ipol_classify u_cls (
    .dst (frm_dst),
    .hit (frm_hit),
    .cls (cls)
  );

  ipol_meter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (frm_start),
    .len      (frm_len),
    .cls      (cls),
    .win_last (win_last),
    .sel      (cfg_class_sel),
    .limit    (cfg_limit),
    .drop_unk (cfg_drop_unknown),
    .dv_o     (dec_valid),
    .fwd_o    (dec_fwd),
    .cls_o    (cls_out)
  );

  assign dec_class = cls_out;
endmodule

// File: rtl/ingress_policer_chk.sv
`timescale 1ns/1ps
module ingress_policer_chk #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             frm_start,
  input logic [47:0]      frm_dst,
  input logic [LEN_W-1:0] frm_len,
  input logic             frm_hit,
  input logic [3:0]       cfg_class_sel,
  input logic [CNT_W-1:0] cfg_limit,
  input logic             cfg_drop_unknown,
  input logic             dec_valid,
  input logic             dec_fwd,
  input logic [1:0]       dec_class
);
  logic unk_uc, known_uc;
  assign unk_uc   = !frm_dst[40] && !frm_hit;
  assign known_uc = !frm_dst[40] && frm_hit;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    frm_start |=> dec_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frm_start |=> (!dec_valid && !dec_fwd));
  p_bcast_class_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frm_start && (&frm_dst)) |=> (dec_class == 2'd3));
  p_unknown_filter_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frm_start && cfg_drop_unknown && unk_uc) |=> !dec_fwd);
  p_unmetered_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frm_start && known_uc && !cfg_class_sel[0]) |=> dec_fwd);
  p_len_over_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frm_start && known_uc && cfg_class_sel[0] && (cfg_limit != '0)
     && (CNT_W'(frm_len) > cfg_limit)) |=> !dec_fwd);
  p_unlimited_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frm_start && (cfg_limit == '0) && !(cfg_drop_unknown && unk_uc)) |=> dec_fwd);
endmodule

bind ingress_policer ingress_policer_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) chk_i (
  .clk              (clk),
  .rst_int_n        (rst_sync_n),
  .frm_start        (frm_start),
  .frm_dst          (frm_dst),
  .frm_len          (frm_len),
  .frm_hit          (frm_hit),
  .cfg_class_sel    (cfg_class_sel),
  .cfg_limit        (cfg_limit),
  .cfg_drop_unknown (cfg_drop_unknown),
  .dec_valid        (dec_valid),
  .dec_fwd          (dec_fwd),
  .dec_class        (dec_class)
);

// File: tb/ingress_policer_tb_top.sv
`timescale 1ns/1ps
module ingress_policer_tb_top;
  localparam int LEN_W   = 11;
  localparam int CNT_W   = 20;
  localparam int WIN_LOG = 8;
  localparam int WIN     = 1 << WIN_LOG;

  localparam logic [47:0] A_BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] A_MC  = 48'h0100_5E00_0001;
  localparam logic [47:0] A_UC  = 48'h0012_3456_789A;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frm_start;
  logic [47:0]      frm_dst;
  logic [LEN_W-1:0] frm_len;
  logic             frm_hit;
  logic [3:0]       cfg_class_sel;
  logic [CNT_W-1:0] cfg_limit;
  logic             cfg_drop_unknown;
  logic             dec_valid, dec_fwd;
  logic [1:0]       dec_class;

  int total = 0;
  int bad   = 0;
  int ecount;
  bit done = 0;

  bit         q_fwd[$];
  logic [1:0] q_cls[$];
  string      q_req[$];

  int m_cnt = 0;
  int m_wid = 0;

  always #2 clk = ~clk;

  ingress_policer #(.LEN_W(LEN_W), .CNT_W(CNT_W), .WIN_LOG(WIN_LOG)) dut_i (
    .clk, .rst_n, .frm_start, .frm_dst, .frm_len, .frm_hit,
    .cfg_class_sel, .cfg_limit, .cfg_drop_unknown,
    .dec_valid, .dec_fwd, .dec_class
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] d, input int l, input bit hit, input string req);
    int         k, wid;
    logic [1:0] c;
    bit         filt, met, ok;
    k = ecount + 1;
    wid = (k - 2) / WIN;
    if (wid != m_wid) begin
      m_cnt = 0;
      m_wid = wid;
    end
    if (&d)        c = 2'd3;
    else if (d[40]) c = 2'd2;
    else if (!hit) c = 2'd1;
    else           c = 2'd0;
    filt = cfg_drop_unknown && (c == 2'd1);
    met  = cfg_class_sel[c];
    ok   = !filt && !(met && (cfg_limit != 0) && (m_cnt + l > int'(cfg_limit)));
    if (ok && met) m_cnt += l;
    q_fwd.push_back(ok);
    q_cls.push_back(c);
    q_req.push_back(req);
    frm_dst   = d;
    frm_len   = LEN_W'(l);
    frm_hit   = hit;
    frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
  endtask

  task automatic go_edge(input int k);
    while (ecount + 1 < k) @(negedge clk);
  endtask

  function automatic int next_tick();
    int k;
    k = ecount + 1;
    while (k < WIN + 2 || ((k - 2) % WIN) != 0) k++;
    return k;
  endfunction

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (q_fwd.size() == 0) begin
        check(1'b0, "R2", "unexpected dec_valid", 1, 0);
      end else begin
        bit         ef;
        logic [1:0] ec;
        string      er;
        ef = q_fwd.pop_front();
        ec = q_cls.pop_front();
        er = q_req.pop_front();
        check(dec_fwd == ef, er, "dec_fwd", int'(dec_fwd), int'(ef));
        check(dec_class == ec, "R1", "dec_class", int'(dec_class), int'(ec));
      end
    end
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t;
    rst_n = 1'b0;
    frm_start = 1'b0; frm_dst = '0; frm_len = '0; frm_hit = 1'b0;
    cfg_class_sel = 4'h0; cfg_limit = '0; cfg_drop_unknown = 1'b0;
    repeat (4) @(negedge clk);
    // R9: quiet outputs while held in reset
    check(dec_valid == 1'b0, "R9", "dec_valid in reset", int'(dec_valid), 0);
    check(dec_fwd == 1'b0, "R9", "dec_fwd in reset", int'(dec_fwd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dec_valid == 1'b0, "R9", "dec_valid after release", int'(dec_valid), 0);

    // R1 / R4: classification with nothing metered
    send(A_BC, 64, 1'b0, "R4");
    send(A_MC, 64, 1'b1, "R4");
    send(A_UC, 64, 1'b1, "R4");
    send(A_UC, 64, 1'b0, "R4");
    @(negedge clk);
    check(dec_valid == 1'b0, "R2", "dec_valid idle", int'(dec_valid), 0);

    // R3: unknown filter
    cfg_drop_unknown = 1'b1;
    send(A_UC, 64, 1'b0, "R3");
    send(A_UC, 64, 1'b1, "R3");
    cfg_drop_unknown = 1'b0;

    // R5 / R6 / R4: broadcast metered, limit 1000
    cfg_class_sel = 4'b1000;
    cfg_limit = 1000;
    t = next_tick();
    go_edge(t);
    send(A_BC, 600, 1'b0, "R5");
    send(A_BC, 500, 1'b0, "R5");
    send(A_BC, 400, 1'b0, "R6");
    send(A_BC, 1, 1'b0, "R5");
    send(A_UC, 1500, 1'b1, "R4");

    // R8: last edge of a window still full, first edge of next is empty
    go_edge(t + WIN - 1);
    send(A_BC, 1, 1'b0, "R8");
    send(A_BC, 1000, 1'b0, "R8");
    send(A_BC, 1, 1'b0, "R8");

    // R3 + meter: filtered unknown frames are not counted
    cfg_class_sel = 4'b0010;
    cfg_limit = 10;
    t = next_tick();
    go_edge(t);
    cfg_drop_unknown = 1'b1;
    send(A_UC, 5, 1'b0, "R3");
    cfg_drop_unknown = 1'b0;
    send(A_UC, 10, 1'b0, "R3");
    send(A_UC, 1, 1'b0, "R5");

    // R4: multicast metered, broadcast not
    cfg_class_sel = 4'b0100;
    cfg_limit = 100;
    t = next_tick();
    go_edge(t);
    send(A_MC, 100, 1'b1, "R5");
    send(A_MC, 1, 1'b1, "R5");
    send(A_BC, 50, 1'b0, "R4");

    // R7: zero limit disables policing
    cfg_class_sel = 4'b1111;
    cfg_limit = 0;
    send(A_BC, 2000, 1'b0, "R7");
    send(A_MC, 2000, 1'b0, "R7");
    send(A_UC, 2000, 1'b1, "R7");

    repeat (4) @(negedge clk);
    check(q_fwd.size() == 0, "R2", "decisions outstanding", q_fwd.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule